// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Controller

This block sits between an in-order queue of decoded integer instructions and two identical single-cycle ALU ports. Every cycle it looks at the two oldest queue entries and decides whether to send none, the oldest alone, or both. It keeps one busy bit per architectural register to track results that are not yet written back. It checks the younger entry of the pair against the older one for read-after-write and write-after-write conflicts. A younger entry never leaves ahead of an older one that is held back.

The decision is made combinationally within a cycle. The count of entries taken goes straight back to the queue so that its head can advance at the same clock edge. The chosen operations, destinations and operand source selects are registered and drive the ALU ports in the next cycle. The ALU reports its results on a two-lane writeback interface during that cycle. A source whose result is being written back in the current cycle counts as ready and is steered to the bypass path of the ALU port that produced it. A dependent chain therefore still issues one instruction per cycle.

Top module: `dual_issue_ctrl`

## Requirements
- R1: Each cycle `issue_cnt` is 0, 1 or 2; when only the oldest entry issues the count is 1, and the oldest entry always goes to port 0 and the next one to port 1.
- R2: Issue is in program order: nothing issues when `hd0_valid` is low, and port 1 never receives an entry unless port 0 receives the older one in the same cycle.
- R3: Issuing an instruction with a nonzero destination marks that register busy; a writeback to it clears the mark. An instruction that reads a busy register with no writeback to it in the same cycle stalls, and so does every younger entry.
- R4: Operand select encoding is 2'b00 register file, 2'b01 bypass from port 0 writeback, 2'b10 bypass from port 1 writeback. A used, nonzero source that matches an active writeback destination in the decision cycle is ready and gets the bypass code of that lane (port 1 wins if both match); otherwise it gets 2'b00.
- R5: If the younger entry reads (through a used source) the nonzero destination of the older entry, only the older entry issues that cycle.
- R6: Two valid, ready entries with no conflict between them both issue in the same cycle; a write-after-read between them is not a conflict. Four such operations, including one whose sources are produced by the previous pair, issue in two cycles.
- R7: Four instructions, each reading the result of the one before, issue one per cycle over four cycles.
- R8: If both entries write the same nonzero destination, only the older entry issues that cycle.
- R9: Register 0 is never busy and never creates a dependency; a source whose use flag is 0 never creates a dependency and gets select 2'b00; a destination of 0 marks nothing busy and causes no write-after-write conflict.
- R10: `p0_*` and `p1_*` are registered: valid, opcode, destination and selects appear in the cycle after the decision, while `issue_cnt` reports the decision in the same cycle.
- R11: While `rst` is high, `issue_cnt` is 0; after a reset edge both port valids are low and every busy bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd0_valid | input | 1 | Oldest queue entry present |
| hd0_op | input | OPC_W | Oldest entry operation code |
| hd0_dst | input | RW | Oldest entry destination register (0 = none) |
| hd0_src_a | input | RW | Oldest entry first source register |
| hd0_src_b | input | RW | Oldest entry second source register |
| hd0_use_a | input | 1 | Oldest entry reads its first source |
| hd0_use_b | input | 1 | Oldest entry reads its second source |
| hd1_valid | input | 1 | Second-oldest queue entry present |
| hd1_op | input | OPC_W | Second entry operation code |
| hd1_dst | input | RW | Second entry destination register (0 = none) |
| hd1_src_a | input | RW | Second entry first source register |
| hd1_src_b | input | RW | Second entry second source register |
| hd1_use_a | input | 1 | Second entry reads its first source |
| hd1_use_b | input | 1 | Second entry reads its second source |
| wb_valid | input | 2 | Writeback active, bit 0 = port 0 lane, bit 1 = port 1 lane |
| wb0_dst | input | RW | Register written back by port 0 |
| wb1_dst | input | RW | Register written back by port 1 |
| issue_cnt | output | 2 | Entries taken from the queue this cycle |
| p0_valid | output | 1 | Port 0 has an operation this cycle |
| p0_op | output | OPC_W | Port 0 operation code |
| p0_dst | output | RW | Port 0 destination register |
| p0_sel_a | output | 2 | Port 0 first operand select |
| p0_sel_b | output | 2 | Port 0 second operand select |
| p1_valid | output | 1 | Port 1 has an operation this cycle |
| p1_op | output | OPC_W | Port 1 operation code |
| p1_dst | output | RW | Port 1 destination register |
| p1_sel_a | output | 2 | Port 1 first operand select |
| p1_sel_b | output | 2 | Port 1 second operand select |

## Verification
The bench builds the block with its defaults, 5-bit register fields (32 registers) and a 4-bit opcode, so register 0, low register numbers and both bypass lanes are all reachable with short programs. A small queue model in the bench advances its head by `issue_cnt`, and the writeback lanes either loop back the port outputs, which models the single-cycle ALU, or are held by the bench. Holding them makes a busy register visible as a stall and lets the bench pick which lane clears it, so the port 1 bypass code and the clearing of the busy bit can be checked at the ports.

// File: rtl/dic_pkg.sv
package dic_pkg;

  // Operand source select carried to each ALU port
  typedef enum logic [1:0] {
    SEL_RF   = 2'b00,
    SEL_BYP0 = 2'b01,
    SEL_BYP1 = 2'b10
  } opsel_e;

endpackage

// File: rtl/dic_scoreboard.sv
module dic_scoreboard #(
  parameter int RW = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           set_en,
  input  logic [RW-1:0]        set_reg0,
  input  logic [RW-1:0]        set_reg1,
  input  logic [1:0]           clr_en,
  input  logic [RW-1:0]        clr_reg0,
  input  logic [RW-1:0]        clr_reg1,
  output logic [(1<<RW)-1:0]   busy
);

  localparam int NREG = 1 << RW;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    if (g == 0) begin : g_zero
      // register 0 is hard-wired and never pending
      assign busy[g] = 1'b0;
    end else begin : g_reg
      logic pend_q;
      logic hit_set;
      logic hit_clr;

      assign hit_set = (set_en[0] && (set_reg0 == RW'(g))) ||
                       (set_en[1] && (set_reg1 == RW'(g)));
      assign hit_clr = (clr_en[0] && (clr_reg0 == RW'(g))) ||
                       (clr_en[1] && (clr_reg1 == RW'(g)));

      // a new issue in the same cycle as a writeback keeps the bit set
      always_ff @(posedge clk) begin
        if (rst)          pend_q <= 1'b0;
        else if (hit_set) pend_q <= 1'b1;
        else if (hit_clr) pend_q <= 1'b0;
      end

      assign busy[g] = pend_q;
    end
  end

endmodule

// File: rtl/dic_src_check.sv
module dic_src_check #(
  parameter int RW = 5
) (
  input  logic [(1<<RW)-1:0] busy,
  input  logic [RW-1:0]      src,
  input  logic               src_used,
  input  logic [1:0]         wb_valid,
  input  logic [RW-1:0]      wb0_dst,
  input  logic [RW-1:0]      wb1_dst,
  output logic               ready,
  output dic_pkg::opsel_e    sel
);

  import dic_pkg::*;

  logic real_src;
  logic hit0;
  logic hit1;

  assign real_src = src_used && (src != '0);
  assign hit0     = wb_valid[0] && (wb0_dst == src);
  assign hit1     = wb_valid[1] && (wb1_dst == src);

  always_comb begin
    ready = 1'b1;
    sel   = SEL_RF;
    if (real_src) begin
      if (hit1) begin
        sel = SEL_BYP1;
      end else if (hit0) begin
        sel = SEL_BYP0;
      end else begin
        ready = !busy[src];
      end
    end
  end

endmodule

// File: rtl/dic_pair_pick.sv
module dic_pair_pick #(
  parameter int RW = 5
) (
  input  logic          v0,
  input  logic          v1,
  input  logic          rdy0,
  input  logic          rdy1,
  input  logic [RW-1:0] dst0,
  input  logic [RW-1:0] dst1,
  input  logic [RW-1:0] y_src_a,
  input  logic [RW-1:0] y_src_b,
  input  logic          y_use_a,
  input  logic          y_use_b,
  output logic          go0,
  output logic          go1
);

  logic old_writes;
  logic raw_hit;
  logic waw_hit;

  assign old_writes = (dst0 != '0);
  assign raw_hit    = old_writes &&
                      ((y_use_a && (y_src_a == dst0)) ||
                       (y_use_b && (y_src_b == dst0)));
  assign waw_hit    = old_writes && (dst1 == dst0);

  // the younger slot can only ride along with the older one
  assign go0 = v0 && rdy0;
  assign go1 = go0 && v1 && rdy1 && !raw_hit && !waw_hit;

endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl #(
  parameter int OPC_W = 4,
  parameter int RW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hd0_valid,
  input  logic [OPC_W-1:0] hd0_op,
  input  logic [RW-1:0]    hd0_dst,
  input  logic [RW-1:0]    hd0_src_a,
  input  logic [RW-1:0]    hd0_src_b,
  input  logic             hd0_use_a,
  input  logic             hd0_use_b,
  input  logic             hd1_valid,
  input  logic [OPC_W-1:0] hd1_op,
  input  logic [RW-1:0]    hd1_dst,
  input  logic [RW-1:0]    hd1_src_a,
  input  logic [RW-1:0]    hd1_src_b,
  input  logic             hd1_use_a,
  input  logic             hd1_use_b,
  input  logic [1:0]       wb_valid,
  input  logic [RW-1:0]    wb0_dst,
  input  logic [RW-1:0]    wb1_dst,
  output logic [1:0]       issue_cnt,
  output logic             p0_valid,
  output logic [OPC_W-1:0] p0_op,
  output logic [RW-1:0]    p0_dst,
  output logic [1:0]       p0_sel_a,
  output logic [1:0]       p0_sel_b,
  output logic             p1_valid,
  output logic [OPC_W-1:0] p1_op,
  output logic [RW-1:0]    p1_dst,
  output logic [1:0]       p1_sel_a,
  output logic [1:0]       p1_sel_b
);

  import dic_pkg::*;

  localparam int NREG  = 1 << RW;
  localparam int NSLOT = 2;
  localparam int NCHK  = NSLOT * 2;

  logic [NREG-1:0] busy;
  logic [RW-1:0]   chk_src  [NCHK];
  logic            chk_used [NCHK];
  logic            chk_rdy  [NCHK];
  opsel_e          chk_sel  [NCHK];
  logic            go0;
  logic            go1;
  logic            take0;
  logic            take1;
  logic [1:0]      set_en;

  // source checks: index 2*slot + operand
  assign chk_src[0]  = hd0_src_a;
  assign chk_src[1]  = hd0_src_b;
  assign chk_src[2]  = hd1_src_a;
  assign chk_src[3]  = hd1_src_b;
  assign chk_used[0] = hd0_use_a;
  assign chk_used[1] = hd0_use_b;
  assign chk_used[2] = hd1_use_a;
  assign chk_used[3] = hd1_use_b;

  for (genvar i = 0; i < NCHK; i++) begin : g_chk
    dic_src_check #(.RW(RW)) u_src (
      .busy     (busy),
      .src      (chk_src[i]),
      .src_used (chk_used[i]),
      .wb_valid (wb_valid),
      .wb0_dst  (wb0_dst),
      .wb1_dst  (wb1_dst),
      .ready    (chk_rdy[i]),
      .sel      (chk_sel[i])
    );
  end

  dic_pair_pick #(.RW(RW)) u_pick (
    .v0      (hd0_valid),
    .v1      (hd1_valid),
    .rdy0    (chk_rdy[0] && chk_rdy[1]),
    .rdy1    (chk_rdy[2] && chk_rdy[3]),
    .dst0    (hd0_dst),
    .dst1    (hd1_dst),
    .y_src_a (hd1_src_a),
    .y_src_b (hd1_src_b),
    .y_use_a (hd1_use_a),
    .y_use_b (hd1_use_b),
    .go0     (go0),
    .go1     (go1)
  );

  assign take0     = go0 && !rst;
  assign take1     = go1 && !rst;
  assign issue_cnt = {1'b0, take0} + {1'b0, take1};

  assign set_en[0] = take0 && (hd0_dst != '0);
  assign set_en[1] = take1 && (hd1_dst != '0);

  dic_scoreboard #(.RW(RW)) u_sb (
    .clk      (clk),
    .rst      (rst),
    .set_en   (set_en),
    .set_reg0 (hd0_dst),
    .set_reg1 (hd1_dst),
    .clr_en   (wb_valid),
    .clr_reg0 (wb0_dst),
    .clr_reg1 (wb1_dst),
    .busy     (busy)
  );

  // registered port outputs feed the ALUs in the following cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      p0_valid <= 1'b0;
      p0_op    <= '0;
      p0_dst   <= '0;
      p0_sel_a <= SEL_RF;
      p0_sel_b <= SEL_RF;
      p1_valid <= 1'b0;
      p1_op    <= '0;
      p1_dst   <= '0;
      p1_sel_a <= SEL_RF;
      p1_sel_b <= SEL_RF;
    end else begin
      p0_valid <= go0;
      p0_op    <= hd0_op;
      p0_dst   <= hd0_dst;
      p0_sel_a <= chk_sel[0];
      p0_sel_b <= chk_sel[1];
      p1_valid <= go1;
      p1_op    <= hd1_op;
      p1_dst   <= hd1_dst;
      p1_sel_a <= chk_sel[2];
      p1_sel_b <= chk_sel[3];
    end
  end

endmodule

// File: rtl/dic_checker.sv
module dic_checker #(
  parameter int OPC_W = 4,
  parameter int RW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             hd0_valid,
  input logic [RW-1:0]    hd0_dst,
  input logic             hd1_valid,
  input logic [RW-1:0]    hd1_dst,
  input logic [RW-1:0]    hd1_src_a,
  input logic [RW-1:0]    hd1_src_b,
  input logic             hd1_use_a,
  input logic             hd1_use_b,
  input logic [1:0]       issue_cnt,
  input logic             p0_valid,
  input logic [1:0]       p0_sel_a,
  input logic [1:0]       p0_sel_b,
  input logic             p1_valid,
  input logic [1:0]       p1_sel_a,
  input logic [1:0]       p1_sel_b
);

  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    issue_cnt != 2'd3);

  a_r2_no_issue_without_head: assert property (@(posedge clk) disable iff (rst)
    !hd0_valid |-> issue_cnt == 2'd0);

  a_r2_port1_needs_port0: assert property (@(posedge clk) disable iff (rst)
    p1_valid |-> p0_valid);

  a_r4_sel_code: assert property (@(posedge clk) disable iff (rst)
    (p0_sel_a != 2'b11) && (p0_sel_b != 2'b11) &&
    (p1_sel_a != 2'b11) && (p1_sel_b != 2'b11));

  a_r5_raw_split: assert property (@(posedge clk) disable iff (rst)
    (hd0_valid && hd1_valid && hd0_dst != '0 &&
     ((hd1_use_a && hd1_src_a == hd0_dst) || (hd1_use_b && hd1_src_b == hd0_dst)))
    |-> issue_cnt != 2'd2);

  a_r8_waw_split: assert property (@(posedge clk) disable iff (rst)
    (hd0_valid && hd1_valid && hd0_dst != '0 && hd1_dst == hd0_dst)
    |-> issue_cnt != 2'd2);

  a_r10_pair_lands: assert property (@(posedge clk) disable iff (rst)
    issue_cnt == 2'd2 |=> p0_valid && p1_valid);

  a_r10_none_lands: assert property (@(posedge clk) disable iff (rst)
    issue_cnt == 2'd0 |=> !p0_valid && !p1_valid);

  a_r11_cnt_in_reset: assert property (@(posedge clk)
    rst |-> issue_cnt == 2'd0);

  a_r11_ports_after_reset: assert property (@(posedge clk)
    rst |=> !p0_valid && !p1_valid);

endmodule

bind dual_issue_ctrl dic_checker #(.OPC_W(OPC_W), .RW(RW)) u_chk (.*);

// File: tb/dual_issue_ctrl_bench.sv
module dual_issue_ctrl_bench;

  localparam int OPC_W = 4;
  localparam int RW    = 5;

  typedef struct packed {
    logic v0, v1;
    logic [RW-1:0] d0, a0, b0;
    logic ua0, ub0;
    logic [RW-1:0] d1, a1, b1;
    logic ua1, ub1;
    logic [1:0] cnt;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1, 1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd4, 5'd5, 5'd6, 1'b1, 1'b1, 2'd2}, // R6 independent
    '{1'b1, 1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd4, 5'd1, 5'd6, 1'b1, 1'b1, 2'd1}, // R5 via src a
    '{1'b1, 1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd4, 5'd5, 5'd1, 1'b1, 1'b1, 2'd1}, // R5 via src b
    '{1'b1, 1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd1, 5'd5, 5'd6, 1'b1, 1'b1, 2'd1}, // R8 same dst
    '{1'b1, 1'b1, 5'd0, 5'd2, 5'd3, 1'b1, 1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 2'd2}, // R9 register 0
    '{1'b1, 1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd4, 5'd1, 5'd1, 1'b0, 1'b0, 2'd2}, // R9 unused fields
    '{1'b0, 1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd4, 5'd5, 5'd6, 1'b1, 1'b1, 2'd0}, // R2 head empty
    '{1'b1, 1'b0, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd4, 5'd5, 5'd6, 1'b1, 1'b1, 2'd1}, // R1 single entry
    '{1'b1, 1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd2, 5'd5, 5'd6, 1'b1, 1'b1, 2'd2}, // R6 WAR allowed
    '{1'b1, 1'b1, 5'd3, 5'd3, 5'd3, 1'b1, 1'b1, 5'd7, 5'd3, 5'd8, 1'b1, 1'b0, 2'd1}  // R5 read-modify
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             hd0_valid, hd0_use_a, hd0_use_b;
  logic             hd1_valid, hd1_use_a, hd1_use_b;
  logic [OPC_W-1:0] hd0_op, hd1_op;
  logic [RW-1:0]    hd0_dst, hd0_src_a, hd0_src_b;
  logic [RW-1:0]    hd1_dst, hd1_src_a, hd1_src_b;
  logic [1:0]       wb_valid;
  logic [RW-1:0]    wb0_dst, wb1_dst;
  logic [1:0]       issue_cnt;
  logic             p0_valid, p1_valid;
  logic [OPC_W-1:0] p0_op, p1_op;
  logic [RW-1:0]    p0_dst, p1_dst;
  logic [1:0]       p0_sel_a, p0_sel_b, p1_sel_a, p1_sel_b;

  dual_issue_ctrl #(.OPC_W(OPC_W), .RW(RW)) u_dual_issue_ctrl (.*);

  // stimulus source: 0 idle, 1 table row, 2 queue program
  int   mode = 0;
  row_t cur  = '0;
  logic [RW-1:0] pd [8];
  logic [RW-1:0] pa [8];
  logic [RW-1:0] pb [8];
  logic          pua [8];
  logic          pub [8];
  int   plen = 0;
  int   ptr  = 0;
  logic load_req = 1'b0;

  // writeback: loop back the ports (single-cycle ALU) or held by the bench
  logic          man = 1'b0;
  logic [1:0]    man_v = 2'b00;
  logic [RW-1:0] man_d0 = '0, man_d1 = '0;

  assign wb_valid = man ? man_v  : {p1_valid, p0_valid};
  assign wb0_dst  = man ? man_d0 : p0_dst;
  assign wb1_dst  = man ? man_d1 : p1_dst;

  always @(posedge clk) begin
    if (load_req)       ptr <= 0;
    else if (mode == 2) ptr <= ptr + int'(issue_cnt);
  end

  always_comb begin
    hd0_valid = 1'b0; hd0_op = '0; hd0_dst = '0; hd0_src_a = '0; hd0_src_b = '0;
    hd0_use_a = 1'b0; hd0_use_b = 1'b0;
    hd1_valid = 1'b0; hd1_op = '0; hd1_dst = '0; hd1_src_a = '0; hd1_src_b = '0;
    hd1_use_a = 1'b0; hd1_use_b = 1'b0;
    if (mode == 1) begin
      hd0_valid = cur.v0; hd0_op = 4'd5; hd0_dst = cur.d0; hd0_src_a = cur.a0;
      hd0_src_b = cur.b0; hd0_use_a = cur.ua0; hd0_use_b = cur.ub0;
      hd1_valid = cur.v1; hd1_op = 4'd9; hd1_dst = cur.d1; hd1_src_a = cur.a1;
      hd1_src_b = cur.b1; hd1_use_a = cur.ua1; hd1_use_b = cur.ub1;
    end else if (mode == 2) begin
      if (ptr < plen) begin
        hd0_valid = 1'b1; hd0_op = 4'(ptr); hd0_dst = pd[ptr]; hd0_src_a = pa[ptr];
        hd0_src_b = pb[ptr]; hd0_use_a = pua[ptr]; hd0_use_b = pub[ptr];
      end
      if (ptr + 1 < plen) begin
        hd1_valid = 1'b1; hd1_op = 4'(ptr + 1); hd1_dst = pd[ptr+1]; hd1_src_a = pa[ptr+1];
        hd1_src_b = pb[ptr+1]; hd1_use_a = pua[ptr+1]; hd1_use_b = pub[ptr+1];
      end
    end
  end

  int n_run  = 0;
  int n_fail = 0;

  task automatic check_eq(input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_instr(input int i, input int d, input int a, input int b,
                           input logic ua, input logic ub);
    pd[i] = RW'(d); pa[i] = RW'(a); pb[i] = RW'(b); pua[i] = ua; pub[i] = ub;
  endtask

  // leaves the program presented at posedge + 1
  task automatic start_prog(input int len);
    plen = len;
    mode = 0;
    load_req = 1'b1;
    tick();
    load_req = 1'b0;
    mode = 2;
  endtask

  function automatic string row_req(input int i);
    case (i)
      0, 8:    return "R6 pair of independent entries";
      1, 2, 9: return "R5 read-after-write inside pair";
      3:       return "R8 same destination in pair";
      4, 5:    return "R9 register 0 or unused source";
      6:       return "R2 older entry absent";
      default: return "R1 single oldest entry";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) tick();
    check_eq(issue_cnt, 0, "R11 count in reset");
    check_eq(p0_valid, 0, "R11 port 0 valid after reset");
    check_eq(p1_valid, 0, "R11 port 1 valid after reset");
    rst = 1'b0;
    tick();

    // table: each row on a clean scoreboard, then an idle cycle drains writebacks
    for (int i = 0; i < NROWS; i++) begin
      cur  = ROWS[i];
      mode = 1;
      #8;
      check_eq(issue_cnt, cur.cnt, row_req(i));
      tick();
      mode = 0;
      check_eq(p0_valid, int'(cur.cnt >= 2'd1), "R10 port 0 valid one cycle later");
      check_eq(p1_valid, int'(cur.cnt == 2'd2), "R10 port 1 valid one cycle later");
      if (cur.cnt >= 2'd1) begin
        check_eq(p0_dst, cur.d0, "R10 port 0 destination");
        check_eq(p0_op, 5, "R10 port 0 opcode");
      end
      tick();
      tick();
    end

    // R7: dependency chain r1 -> r4 -> r6 -> r8
    set_instr(0, 1, 2, 3, 1'b1, 1'b1);
    set_instr(1, 4, 1, 5, 1'b1, 1'b1);
    set_instr(2, 6, 4, 7, 1'b1, 1'b1);
    set_instr(3, 8, 6, 9, 1'b1, 1'b1);
    start_prog(4);
    #8; check_eq(issue_cnt, 1, "R7 chain cycle 1");
    tick();
    #8; check_eq(issue_cnt, 1, "R7 chain cycle 2");
    tick();
    check_eq(p0_sel_a, 1, "R4 chain operand bypassed from port 0");
    check_eq(p1_valid, 0, "R7 second port idle");
    #8; check_eq(issue_cnt, 1, "R7 chain cycle 3");
    tick();
    #8; check_eq(issue_cnt, 1, "R7 chain cycle 4");
    tick();
    #8; check_eq(issue_cnt, 0, "R7 chain done in four cycles");
    mode = 0;
    tick(); tick();

    // R6: two pairs, the second reading results of the first
    set_instr(0, 1, 2, 3, 1'b1, 1'b1);
    set_instr(1, 4, 5, 6, 1'b1, 1'b1);
    set_instr(2, 7, 1, 4, 1'b1, 1'b1);
    set_instr(3, 8, 9, 10, 1'b1, 1'b1);
    start_prog(4);
    #8; check_eq(issue_cnt, 2, "R6 first pair");
    tick();
    #8; check_eq(issue_cnt, 2, "R6 second pair");
    tick();
    check_eq(p0_sel_a, 1, "R4 src a from port 0 lane");
    check_eq(p0_sel_b, 2, "R4 src b from port 1 lane");
    check_eq(p1_sel_a, 0, "R4 independent operand from register file");
    #8; check_eq(issue_cnt, 0, "R6 four operations in two cycles");
    mode = 0;
    tick(); tick();

    // R3: writeback held by the bench
    man = 1'b1;
    man_v = 2'b00;
    set_instr(0, 1, 2, 3, 1'b1, 1'b1);
    set_instr(1, 5, 1, 6, 1'b1, 1'b1);
    set_instr(2, 7, 1, 0, 1'b1, 1'b1);
    set_instr(3, 9, 1, 1, 1'b1, 1'b1);
    start_prog(4);
    #8; check_eq(issue_cnt, 1, "R5 split before hold");
    tick();
    #8; check_eq(issue_cnt, 0, "R3 busy source stalls");
    tick();
    #8; check_eq(issue_cnt, 0, "R3 stall persists without writeback");
    tick();
    man_v  = 2'b10;
    man_d1 = 5'd1;
    #8; check_eq(issue_cnt, 2, "R3 writeback releases stalled pair");
    tick();
    man_v = 2'b00;
    check_eq(p0_sel_a, 2, "R4 port 1 lane bypass on port 0");
    check_eq(p1_sel_a, 2, "R4 port 1 lane bypass on port 1");
    check_eq(p1_sel_b, 0, "R9 register 0 source reads register file");
    #8; check_eq(issue_cnt, 1, "R3 bit cleared after writeback");
    tick();
    check_eq(p0_sel_a, 0, "R3 cleared register read from register file");
    #8; check_eq(issue_cnt, 0, "R3 program finished");

    // R11: reset clears pending registers 5, 7 and 9
    rst = 1'b1;
    set_instr(0, 2, 5, 7, 1'b1, 1'b1);
    start_prog(1);
    #8; check_eq(issue_cnt, 0, "R11 no issue during reset");
    tick();
    check_eq(p0_valid, 0, "R11 port 0 low after reset edge");
    rst = 1'b0;
    man = 1'b0;
    #8; check_eq(issue_cnt, 1, "R11 busy bits cleared by reset");
    tick();
    check_eq(p0_valid, 1, "R11 issue after reset");
    check_eq(p0_sel_a, 0, "R11 operand from register file after reset");
    mode = 0;
    tick(); tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule